// File: doc/BRIEF.md
# PWM-Synchronised Dual Current-Sample Sequencer

This block takes two current samples each time the PWM carrier counter passes its midpoint. Two converters are involved. Converter 1 always reads current amplifier 1. Converter 2 has an input multiplexer that this block drives, and that multiplexer chooses between current amplifier 2 and the internal output route of amplifier 3.

A single trigger event runs two passes. Path A goes first, with converter 2 reading amplifier 2. Path B follows, with converter 2 reading the amplifier 3 internal route. On each pass the block raises one request to both converters. It then collects a conversion-complete flag and an end-of-sequence flag from each converter, and captures each result when its conversion-complete flag arrives. Each pass is guarded by a timeout.

Once a pass closes, the block stores the raw counts together with a timeout flag, a rail flag and a validity flag for that path. A trigger that arrives while the two passes are still running is dropped and counted. Scaling to amperes, reconstruction of the third phase current and any coordinate transforms belong to later blocks.

Top module: `cs_dual_sampler`

## Requirements
- R1: While reset is held and immediately after it, `busy`, `conv_req`, `conv2_src`, `seq_done`, every path flag, every result and `ovr_cnt` are all 0.
- R2: A trigger occurs on the first clock in which `carrier_cnt` equals TRIG_AT (default 399, for a carrier that counts 0 to 799). If the count stays at TRIG_AT for several clocks, only one trigger results. Any other count value never triggers.
- R3: Each accepted trigger produces exactly two single-clock `conv_req` pulses. During the first pulse `conv2_src` is 0, which selects amplifier 2 (path A). During the second pulse `conv2_src` is 1, which selects the amplifier 3 internal route (path B).
- R4: A path completes only after both a conversion-complete pulse and an end-of-sequence pulse have arrived from both converters, in any order and in any cycles. Each result is captured unscaled on its converter's conversion-complete pulse. Converter 1's result goes to `pX_res1` and converter 2's result goes to `pX_res2`.
- R5: If any of the four flags has not arrived within TMO clocks (default 256) counted from the request cycle, the path sets `pX_to`, clears `pX_rail` and `pX_ok`, and leaves its result fields unchanged. The sequence then moves on.
- R6: On a completed path, `pX_rail` is set when either result equals 0 or equals 2^DATA_W-1 (4095 for 12 bits).
- R7: `pX_ok` is 1 exactly when the path completed, `pX_to` is clear and `pX_rail` is clear.
- R8: A trigger that arrives while `busy` is 1 starts no request and changes no result. It increments `ovr_cnt`, which saturates at its maximum value.
- R9: `seq_done` is a one-clock pulse in the same cycle that path B's outputs update and `busy` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_cnt | input | CNT_W | PWM carrier counter value |
| conv_req | output | 1 | Start-conversion pulse to both converters |
| conv2_src | output | 1 | Converter 2 input select: 0 = amplifier 2, 1 = amplifier 3 internal route |
| c1_eoc | input | 1 | Converter 1 conversion complete |
| c1_eos | input | 1 | Converter 1 end of sequence |
| c1_data | input | DATA_W | Converter 1 result |
| c2_eoc | input | 1 | Converter 2 conversion complete |
| c2_eos | input | 1 | Converter 2 end of sequence |
| c2_data | input | DATA_W | Converter 2 result |
| busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | Both paths finished |
| pa_ok | output | 1 | Path A valid |
| pa_to | output | 1 | Path A timed out |
| pa_rail | output | 1 | Path A result at a rail |
| pa_res1 | output | DATA_W | Path A amplifier 1 count |
| pa_res2 | output | DATA_W | Path A amplifier 2 count |
| pb_ok | output | 1 | Path B valid |
| pb_to | output | 1 | Path B timed out |
| pb_rail | output | 1 | Path B result at a rail |
| pb_res1 | output | DATA_W | Path B amplifier 1 count |
| pb_res2 | output | DATA_W | Path B amplifier 3 internal count |
| ovr_cnt | output | OVR_W | Dropped-trigger count, saturating |

## Verification
The bench holds the carrier count at the trigger value for several clocks, which catches a level-sensitive design that would start repeated sequences. It also feeds counts just below and just above the trigger value, which catches a decoder that is too loose.

The converter stub delivers conversion-complete and end-of-sequence pulses with independent random delays. Some runs deliver only one flag late. A design that closed a path on the first flag alone would report stale counts, and a design that ignored a missing end-of-sequence flag would never time out.

Result values of 0, 1, 4094 and 4095 test the edges of the rail comparison. Retriggering in the middle of a sequence checks that the overrun is counted and that no extra request pulse appears. A stale late pulse left over from a timed-out path must not complete the path that follows it.

// File: rtl/cs_pkg.sv
package cs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PATH_A = 2'd1,
        ST_PATH_B = 2'd2
    } seq_st_e;
endpackage

// File: rtl/cs_trig_detect.sv
module cs_trig_detect #(
    parameter int CNT_W   = 10,
    parameter int TRIG_AT = 399
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] carrier_cnt,
    output logic             trig
);
    typedef struct packed {
        logic hit;
    } trig_st_t;

    trig_st_t q, d;
    logic     hit_now;

    always_comb begin
        hit_now = (carrier_cnt == CNT_W'(TRIG_AT));
        d       = q;
        d.hit   = hit_now;
        trig    = hit_now && !q.hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2
    single_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig);
endmodule

// File: rtl/cs_conv_track.sv
module cs_conv_track #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              eoc,
    input  logic              eos,
    input  logic [DATA_W-1:0] data,
    output logic              got_eoc,
    output logic              got_eos,
    output logic [DATA_W-1:0] result
);
    typedef struct packed {
        logic              eoc_seen;
        logic              eos_seen;
        logic [DATA_W-1:0] res;
    } trk_t;

    trk_t q, d;

    always_comb begin
        d = q;
        if (clr) begin
            d.eoc_seen = 1'b0;
            d.eos_seen = 1'b0;
        end
        if (eoc) begin
            d.eoc_seen = 1'b1;
            d.res      = data;
        end
        if (eos) d.eos_seen = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign got_eoc = q.eoc_seen;
    assign got_eos = q.eos_seen;
    assign result  = q.res;

    // R4
    eoc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (got_eoc && !clr) |=> got_eoc);
    // R4
    eos_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (got_eos && !clr) |=> got_eos);
endmodule

// File: rtl/cs_ovr_count.sv
module cs_ovr_count #(
    parameter int OVR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [OVR_W-1:0] count
);
    localparam logic [OVR_W-1:0] TOP = '1;

    typedef struct packed {
        logic [OVR_W-1:0] n;
    } ovr_t;

    ovr_t q, d;

    always_comb begin
        d = q;
        if (inc && q.n != TOP) d.n = q.n + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count = q.n;

    // R8
    ovr_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> count >= $past(count));
endmodule

// File: rtl/cs_dual_sampler.sv
module cs_dual_sampler
    import cs_pkg::*;
#(
    parameter int CNT_W   = 10,
    parameter int TRIG_AT = 399,
    parameter int DATA_W  = 12,
    parameter int TMO     = 256,
    parameter int OVR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  carrier_cnt,
    output logic              conv_req,
    output logic              conv2_src,
    input  logic              c1_eoc,
    input  logic              c1_eos,
    input  logic [DATA_W-1:0] c1_data,
    input  logic              c2_eoc,
    input  logic              c2_eos,
    input  logic [DATA_W-1:0] c2_data,
    output logic              busy,
    output logic              seq_done,
    output logic              pa_ok,
    output logic              pa_to,
    output logic              pa_rail,
    output logic [DATA_W-1:0] pa_res1,
    output logic [DATA_W-1:0] pa_res2,
    output logic              pb_ok,
    output logic              pb_to,
    output logic              pb_rail,
    output logic [DATA_W-1:0] pb_res1,
    output logic [DATA_W-1:0] pb_res2,
    output logic [OVR_W-1:0]  ovr_cnt
);
    localparam int NCONV = 2;
    localparam int TMR_W = $clog2(TMO + 1);
    localparam logic [TMR_W-1:0] TMR_END = TMR_W'(TMO);

    typedef struct packed {
        logic              ok;
        logic              to;
        logic              rail;
        logic [DATA_W-1:0] r1;
        logic [DATA_W-1:0] r2;
    } path_t;

    typedef struct packed {
        seq_st_e          st;
        logic             req;
        logic             done;
        logic [TMR_W-1:0] tmr;
        path_t            pa;
        path_t            pb;
    } seq_t;

    seq_t q, d;

    logic              trig;
    logic              all_in;
    logic              fin;
    logic              tmo_hit;
    logic              any_rail;
    logic              ovr_inc;
    logic [NCONV-1:0]  eoc_v, eos_v, got_eoc, got_eos, rail_v;
    logic [DATA_W-1:0] dat_v [NCONV];
    logic [DATA_W-1:0] trk_res [NCONV];

    assign eoc_v    = {c2_eoc, c1_eoc};
    assign eos_v    = {c2_eos, c1_eos};
    assign dat_v[0] = c1_data;
    assign dat_v[1] = c2_data;

    cs_trig_detect #(.CNT_W(CNT_W), .TRIG_AT(TRIG_AT)) u_trig (
        .clk         (clk),
        .rst_n       (rst_n),
        .carrier_cnt (carrier_cnt),
        .trig        (trig)
    );

    for (genvar gi = 0; gi < NCONV; gi++) begin : g_trk
        cs_conv_track #(.DATA_W(DATA_W)) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (q.req),
            .eoc     (eoc_v[gi]),
            .eos     (eos_v[gi]),
            .data    (dat_v[gi]),
            .got_eoc (got_eoc[gi]),
            .got_eos (got_eos[gi]),
            .result  (trk_res[gi])
        );
        assign rail_v[gi] = (trk_res[gi] == '0) || (trk_res[gi] == '1);
    end

    assign ovr_inc = trig && (q.st != ST_IDLE);

    cs_ovr_count #(.OVR_W(OVR_W)) u_ovr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ovr_inc),
        .count (ovr_cnt)
    );

    function automatic path_t close_path(input path_t old, input logic timed_out,
                                         input logic rail, input logic [DATA_W-1:0] v1,
                                         input logic [DATA_W-1:0] v2);
        path_t p;
        p = old;
        if (timed_out) begin
            p.to   = 1'b1;
            p.rail = 1'b0;
            p.ok   = 1'b0;
        end else begin
            p.to   = 1'b0;
            p.rail = rail;
            p.ok   = !rail;
            p.r1   = v1;
            p.r2   = v2;
        end
        return p;
    endfunction

    always_comb begin
        d        = q;
        d.req    = 1'b0;
        d.done   = 1'b0;
        all_in   = !q.req && (&got_eoc) && (&got_eos);
        any_rail = |rail_v;
        fin      = 1'b0;
        tmo_hit  = 1'b0;
        if (q.st != ST_IDLE) begin
            if (all_in) begin
                fin = 1'b1;
            end else if (q.tmr == TMR_END) begin
                fin     = 1'b1;
                tmo_hit = 1'b1;
            end else begin
                d.tmr = q.tmr + 1'b1;
            end
        end
        case (q.st)
            ST_IDLE: begin
                if (trig) begin
                    d.st  = ST_PATH_A;
                    d.req = 1'b1;
                    d.tmr = '0;
                end
            end
            ST_PATH_A: begin
                if (fin) begin
                    d.pa  = close_path(q.pa, tmo_hit, any_rail, trk_res[0], trk_res[1]);
                    d.st  = ST_PATH_B;
                    d.req = 1'b1;
                    d.tmr = '0;
                end
            end
            ST_PATH_B: begin
                if (fin) begin
                    d.pb   = close_path(q.pb, tmo_hit, any_rail, trk_res[0], trk_res[1]);
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign conv_req  = q.req;
    assign conv2_src = (q.st == ST_PATH_B);
    assign busy      = (q.st != ST_IDLE);
    assign seq_done  = q.done;
    assign pa_ok     = q.pa.ok;
    assign pa_to     = q.pa.to;
    assign pa_rail   = q.pa.rail;
    assign pa_res1   = q.pa.r1;
    assign pa_res2   = q.pa.r2;
    assign pb_ok     = q.pb.ok;
    assign pb_to     = q.pb.to;
    assign pb_rail   = q.pb.rail;
    assign pb_res1   = q.pb.r1;
    assign pb_res2   = q.pb.r2;

    // R3
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> busy);
    // R3
    src_b_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv2_src) |-> conv_req);
    // R5
    to_blocks_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_to |-> !pa_ok) and (pb_to |-> !pb_ok));
    // R7
    rail_blocks_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_rail |-> !pa_ok) and (pb_rail |-> !pb_ok));
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (!busy && $past(busy)));
endmodule

// File: tb/cs_dual_sampler_bench.sv
module cs_dual_sampler_bench;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [9:0]    carrier_cnt = '0;
    logic          conv_req, conv2_src, busy, seq_done;
    logic          c1_eoc = 0, c1_eos = 0, c2_eoc = 0, c2_eos = 0;
    logic [DW-1:0] c1_data = '0, c2_data = '0;
    logic          pa_ok, pa_to, pa_rail, pb_ok, pb_to, pb_rail;
    logic [DW-1:0] pa_res1, pa_res2, pb_res1, pb_res2;
    logic [7:0]    ovr_cnt;

    always #10 clk = ~clk;

    cs_dual_sampler u_cs_dual_sampler (
        .clk(clk), .rst_n(rst_n), .carrier_cnt(carrier_cnt),
        .conv_req(conv_req), .conv2_src(conv2_src),
        .c1_eoc(c1_eoc), .c1_eos(c1_eos), .c1_data(c1_data),
        .c2_eoc(c2_eoc), .c2_eos(c2_eos), .c2_data(c2_data),
        .busy(busy), .seq_done(seq_done),
        .pa_ok(pa_ok), .pa_to(pa_to), .pa_rail(pa_rail),
        .pa_res1(pa_res1), .pa_res2(pa_res2),
        .pb_ok(pb_ok), .pb_to(pb_to), .pb_rail(pb_rail),
        .pb_res1(pb_res1), .pb_res2(pb_res2),
        .ovr_cnt(ovr_cnt)
    );

    int checks = 0;
    int errors = 0;

    // stub settings: index 0..3 = c1 eoc, c1 eos, c2 eoc, c2 eos
    int lat_a [4];
    int lat_b [4];
    logic [DW-1:0] v1a, v2a, v1b, v3b;
    int cd [4];
    logic cur_src = 1'b0;
    int req_count = 0;
    logic src_log [8];

    always @(posedge clk) begin
        if (conv_req) begin
            if (req_count < 8) src_log[req_count] = conv2_src;
            req_count = req_count + 1;
            cur_src  <= conv2_src;
            for (int k = 0; k < 4; k++) cd[k] <= conv2_src ? lat_b[k] : lat_a[k];
            c1_eoc <= 0; c1_eos <= 0; c2_eoc <= 0; c2_eos <= 0;
        end else begin
            for (int k = 0; k < 4; k++) if (cd[k] > 0) cd[k] <= cd[k] - 1;
            c1_eoc <= (cd[0] == 1);
            c1_eos <= (cd[1] == 1);
            c2_eoc <= (cd[2] == 1);
            c2_eos <= (cd[3] == 1);
        end
        c1_data <= cur_src ? v1b : v1a;
        c2_data <= cur_src ? v3b : v2a;
    end

    function automatic logic exp_rail(input logic [DW-1:0] v);
        return (v == 0) || (v == 4095);
    endfunction

    function automatic logic exp_late(input int l0, input int l1, input int l2, input int l3);
        return (l0 > 256) || (l1 > 256) || (l2 > 256) || (l3 > 256);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic fire(input int hold);
        @(negedge clk);
        carrier_cnt = 10'd399;
        repeat (hold) @(negedge clk);
        carrier_cnt = 10'd0;
    endtask

    int ndone;
    task automatic wait_done();
        bit seen = busy;
        ndone = 0;
        for (int i = 0; i < 3000; i++) begin
            if (seq_done) ndone++;
            if (busy) seen = 1;
            if (seen && !busy) break;
            if (i == 2999) check("R9", "watchdog sequence end", 0, 1);
            @(negedge clk);
        end
        @(negedge clk);
        if (seq_done) ndone++;
    endtask

    task automatic run_event(input string tag);
        int r0 = req_count;
        logic ea_to, eb_to, ea_rl, eb_rl;
        logic [DW-1:0] old_a1, old_a2, old_b1, old_b2;
        old_a1 = pa_res1; old_a2 = pa_res2; old_b1 = pb_res1; old_b2 = pb_res2;
        ea_to = exp_late(lat_a[0], lat_a[1], lat_a[2], lat_a[3]);
        eb_to = exp_late(lat_b[0], lat_b[1], lat_b[2], lat_b[3]);
        ea_rl = !ea_to && (exp_rail(v1a) || exp_rail(v2a));
        eb_rl = !eb_to && (exp_rail(v1b) || exp_rail(v3b));
        fire(1);
        wait_done();
        check("R9", {tag, " done pulses"}, ndone, 1);
        check("R3", {tag, " request count"}, req_count - r0, 2);
        if (req_count - r0 == 2 && r0 + 1 < 8) begin
            check("R3", {tag, " first src"}, int'(src_log[r0]), 0);
            check("R3", {tag, " second src"}, int'(src_log[r0+1]), 1);
        end
        check("R5", {tag, " A timeout"}, pa_to, ea_to);
        check("R5", {tag, " B timeout"}, pb_to, eb_to);
        check("R6", {tag, " A rail"}, pa_rail, ea_rl);
        check("R6", {tag, " B rail"}, pb_rail, eb_rl);
        check("R7", {tag, " A ok"}, pa_ok, !ea_to && !ea_rl);
        check("R7", {tag, " B ok"}, pb_ok, !eb_to && !eb_rl);
        check("R4", {tag, " A res1"}, pa_res1, ea_to ? old_a1 : v1a);
        check("R4", {tag, " A res2"}, pa_res2, ea_to ? old_a2 : v2a);
        check("R4", {tag, " B res1"}, pb_res1, eb_to ? old_b1 : v1b);
        check("R4", {tag, " B res2"}, pb_res2, eb_to ? old_b2 : v3b);
    endtask

    function automatic logic [DW-1:0] rand_val();
        int r = $urandom % 10;
        if (r == 0) return 12'd0;
        if (r == 1) return 12'd4095;
        return DW'($urandom % 4096);
    endfunction

    task automatic set_lat(input int l);
        for (int k = 0; k < 4; k++) begin lat_a[k] = l; lat_b[k] = l; end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int k = 0; k < 4; k++) cd[k] = 0;
        set_lat(5);
        v1a = 12'd100; v2a = 12'd200; v1b = 12'd300; v3b = 12'd400;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1", "busy at reset", busy, 0);
        check("R1", "req at reset", conv_req, 0);
        check("R1", "ok/flags at reset", {pa_ok, pa_to, pa_rail, pb_ok, pb_to, pb_rail}, 0);
        check("R1", "results at reset", pa_res1 | pa_res2 | pb_res1 | pb_res2, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ovr after reset", ovr_cnt, 0);
        check("R1", "src after reset", conv2_src, 0);

        // R2 near values do not trigger
        carrier_cnt = 10'd398; @(negedge clk);
        carrier_cnt = 10'd400; @(negedge clk);
        carrier_cnt = 10'd0;   @(negedge clk); @(negedge clk);
        check("R2", "no trigger off midpoint", busy, 0);
        check("R2", "no request off midpoint", req_count, 0);

        // R2 held level gives a single event
        begin
            int r0 = req_count;
            fire(6);
            wait_done();
            check("R2", "held trigger requests", req_count - r0, 2);
            check("R2", "held trigger overrun", ovr_cnt, 0);
        end

        // directed rail edges, R6
        v1a = 12'd1; v2a = 12'd4094; v1b = 12'd0; v3b = 12'd2000;
        run_event("rail_edge");
        v1a = 12'd50; v2a = 12'd60; v1b = 12'd70; v3b = 12'd4095;
        run_event("rail_top");

        // R4 eos late but in window, eoc early; R5 eos-only timeout on B conv2
        set_lat(3); lat_a[3] = 200; lat_b[3] = 400;
        v1a = 12'd11; v2a = 12'd22; v1b = 12'd33; v3b = 12'd44;
        run_event("eos_late");

        // R5 path A timeout, stale pulse must not leak into B
        set_lat(4); lat_a[2] = 400;
        v1a = 12'd7; v2a = 12'd8; v1b = 12'd9; v3b = 12'd10;
        run_event("a_timeout");

        // R8 overrun while busy
        begin
            int r0;
            logic [DW-1:0] hold_b1;
            set_lat(60);
            v1a = 12'd500; v2a = 12'd600; v1b = 12'd700; v3b = 12'd800;
            run_event("pre_ovr");
            hold_b1 = pb_res1;
            r0 = req_count;
            v1b = 12'd900;
            fire(1);
            fire(1);
            fire(1);
            check("R8", "overrun increments", ovr_cnt, 2);
            check("R8", "no request from overrun", req_count - r0, 1);
            check("R8", "B result held mid-sequence", pb_res1, hold_b1);
            wait_done();
            check("R8", "sequence finished normally", req_count - r0, 2);
            check("R8", "overrun count kept", ovr_cnt, 2);
        end

        // random events
        for (int n = 0; n < 24; n++) begin
            for (int k = 0; k < 4; k++) begin
                lat_a[k] = 1 + int'($urandom % 40);
                lat_b[k] = 1 + int'($urandom % 40);
            end
            if ($urandom % 6 == 0) lat_a[$urandom % 4] = 400;
            if ($urandom % 6 == 0) lat_b[$urandom % 4] = 400;
            v1a = rand_val(); v2a = rand_val(); v1b = rand_val(); v3b = rand_val();
            run_event("random");
            repeat ($urandom % 5) @(negedge clk);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule